// File: doc/BRIEF.md
# Modem Line Status and Change Detector

This block watches four asynchronous modem control inputs (carrier detect, ring indicator, data-set-ready and clear-to-send). It brings each one into the system clock domain and presents its current level in a 32-bit status word. For every line it keeps a sticky flag that records that the line has changed since software last cleared it. A single event output is high while any of those flags is set, so it can feed an interrupt controller directly as the "modem status changed" source.

Carrier detect, data-set-ready and clear-to-send flag a change in either direction. The ring indicator flags only the end of a ring, when the line goes from asserted to deasserted. Software clears flags by writing ones to them at the register offset. The same word also holds one plain read/write bit that selects the flow-control mode. This block stores that bit and exposes it, and does not act on it.

Top module: `modem_status_detect`

## Requirements
- R1: While and after synchronous reset, status_word is all zero and dms_event is low.
- R2: Line levels appear in the word at bit 7 (carrier detect), bit 6 (ring), bit 5 (data-set-ready) and bit 4 (clear-to-send), where 1 means asserted. An input change made before rising edge k is visible after rising edge k+1.
- R3: A change in either direction of carrier detect, data-set-ready or clear-to-send sets flag bit 3, 1 or 0 respectively, visible after the edge that follows the level update. A flag never sets without such a change.
- R4: The ring flag at bit 2 sets only when the ring level goes from 1 to 0. A 0 to 1 ring transition leaves the flag unchanged.
- R5: A write (reg_wr high) with reg_addr equal to 0x28 clears every flag whose reg_wdata bit in 3:0 is 1. Flags whose bit is 0 keep their value.
- R6: A flag whose line change is detected in the same cycle as a clearing write stays set.
- R7: Bit 8 is the flow-control mode bit. A write at offset 0x28 loads it from reg_wdata[8], and it holds otherwise.
- R8: Bits 31:9 always read as zero. Writes cannot alter bits 7:4. Writes at any other address change nothing.
- R9: dms_event is high exactly when at least one of bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dcd_in | input | 1 | Asynchronous carrier-detect input, 1 = asserted |
| ri_in | input | 1 | Asynchronous ring-indicator input, 1 = asserted |
| dsr_in | input | 1 | Asynchronous data-set-ready input, 1 = asserted |
| cts_in | input | 1 | Asynchronous clear-to-send input, 1 = asserted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Mode bit, line levels and change flags |
| dms_event | output | 1 | High while any change flag is set |

## Verification
The assertions assume that reg_addr, reg_wdata and reg_wr are synchronous to clk and settle before each rising edge. They also assume that each modem input holds one level across any sampling edge, even though it may change in any cycle. The bench drives every input only on the falling edge, so the synchronisers see clean levels. It toggles lines in every cycle while clearing writes repeat, which places changes and clears in the same cycle. Its random phase mixes writes at the register offset, writes at a neighbouring address, and writes whose bits 7:4 are set.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;

    localparam int unsigned LINE_CNT  = 4;
    localparam int unsigned WORD_W    = 32;

    // line index = flag bit position; level bit = index + LVL_LSB
    localparam int unsigned LN_CTS    = 0;
    localparam int unsigned LN_DSR    = 1;
    localparam int unsigned LN_RING   = 2;
    localparam int unsigned LN_DCD    = 3;

    localparam int unsigned FLG_LSB   = 0;
    localparam int unsigned LVL_LSB   = 4;
    localparam int unsigned MODE_BIT  = 8;
    localparam int unsigned USED_BITS = MODE_BIT + 1;

    // lines that flag only on an asserted-to-deasserted transition
    localparam logic [LINE_CNT-1:0] TRAIL_ONLY = LINE_CNT'(1) << LN_RING;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    typedef struct packed {
        logic      fc_mode;
        line_vec_t level;
        line_vec_t flag;
    } msr_fields_t;

    function automatic logic [WORD_W-1:0] pack_word(input msr_fields_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_BIT]                       = f.fc_mode;
        w[LVL_LSB +: LINE_CNT]            = f.level;
        w[FLG_LSB +: LINE_CNT]            = f.flag;
        return w;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign sync_out = stage[LAST];

    // R2
    sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (sync_out == $past(stage[LAST-1])));

endmodule

// File: rtl/msd_edge.sv
module msd_edge #(
    parameter int unsigned           WIDTH      = 4,
    parameter logic [WIDTH-1:0]      TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] change
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (TRAIL_MASK[i]) begin : g_trail
            assign change[i] = prev_q[i] & ~level[i];
        end else begin : g_any
            assign change[i] = prev_q[i] ^ level[i];
        end
    end

endmodule

// File: rtl/msd_flags.sv
module msd_flags #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] change,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic             mode_wval,
    output logic [WIDTH-1:0] flag_q,
    output logic             mode_q
);
    logic [WIDTH-1:0] kept;

    always_comb begin
        kept = flag_q;
        if (wr_hit) kept = flag_q & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            mode_q <= 1'b0;
        end else begin
            flag_q <= kept | change;
            if (wr_hit) mode_q <= mode_wval;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            change[i] |=> flag_q[i]);
        // R5
        clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && clr_mask[i] && !change[i]) |=> !flag_q[i]);
        // R3
        hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_hit && !change[i]) |=> (flag_q[i] == $past(flag_q[i])));
    end

    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (mode_q == $past(mode_wval)));

endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
    import modem_stat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned REG_OFFSET  = 'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dcd_in,
    input  logic              ri_in,
    input  logic              dsr_in,
    input  logic              cts_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       status_word,
    output logic              dms_event
);
    line_vec_t   raw_lines;
    line_vec_t   lvl;
    line_vec_t   chg;
    line_vec_t   flg;
    logic        mode;
    logic        wr_hit;
    msr_fields_t fields;

    always_comb begin
        raw_lines          = '0;
        raw_lines[LN_DCD]  = dcd_in;
        raw_lines[LN_RING] = ri_in;
        raw_lines[LN_DSR]  = dsr_in;
        raw_lines[LN_CTS]  = cts_in;
    end

    assign wr_hit = reg_wr && (reg_addr == ADDR_W'(REG_OFFSET));

    msd_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(raw_lines), .sync_out(lvl)
    );

    msd_edge #(.WIDTH(LINE_CNT), .TRAIL_MASK(TRAIL_ONLY)) u_edge (
        .clk(clk), .rst(rst), .level(lvl), .change(chg)
    );

    msd_flags #(.WIDTH(LINE_CNT)) u_flags (
        .clk(clk), .rst(rst), .change(chg), .wr_hit(wr_hit),
        .clr_mask(reg_wdata[FLG_LSB +: LINE_CNT]),
        .mode_wval(reg_wdata[MODE_BIT]),
        .flag_q(flg), .mode_q(mode)
    );

    always_comb begin
        fields.fc_mode = mode;
        fields.level   = lvl;
        fields.flag    = flg;
    end

    assign status_word = pack_word(fields);
    assign dms_event   = |flg;

    // R9
    event_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dms_event && !wr_hit) |=> dms_event);
    // R4
    ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !status_word[FLG_LSB+LN_RING] && lvl[LN_RING]) |=>
            !status_word[FLG_LSB+LN_RING]);
    // R8
    foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !wr_hit && !(|chg)) |=> $stable(status_word[USED_BITS-1:0] & ~(32'hF << LVL_LSB)));

endmodule

// File: tb/tb_modem_status_detect.sv
module tb_modem_status_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dcd_in = 0, ri_in = 0, dsr_in = 0, cts_in = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] status_word;
    logic        dms_event;

    always #5 clk = ~clk;

    modem_status_detect dut (
        .clk(clk), .rst(rst), .dcd_in(dcd_in), .ri_in(ri_in),
        .dsr_in(dsr_in), .cts_in(cts_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .status_word(status_word), .dms_event(dms_event)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string phase = "reset";

    // reference model state: bit order {dcd, ring, dsr, cts}
    bit [3:0] m_first, m_level, m_old, m_flags;
    bit       m_mode;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_first = '0; m_level = '0; m_old = '0; m_flags = '0; m_mode = 0;
        end else begin
            bit [3:0] seen;
            bit       hit;
            hit = reg_wr && (reg_addr == 8'h28);
            for (int i = 0; i < 4; i++) begin
                if (i == 2) seen[i] = m_old[i] && !m_level[i];
                else        seen[i] = m_old[i] != m_level[i];
            end
            if (hit) begin
                m_flags = m_flags & ~reg_wdata[3:0];
                m_mode  = reg_wdata[8];
            end
            m_flags = m_flags | seen;
            m_old   = m_level;
            m_level = m_first;
            m_first = {dcd_in, ri_in, dsr_in, cts_in};
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h at cycle %0d",
                     req, phase, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check(status_word[31:9] == '0, "R8", 32'(status_word[31:9]), 32'h0);
        check(status_word[8] == m_mode, "R7", 32'(status_word[8]), 32'(m_mode));
        check(status_word[7:4] == m_level, "R2", 32'(status_word[7:4]), 32'(m_level));
        check({status_word[3], status_word[1:0]} == {m_flags[3], m_flags[1:0]},
              "R3", 32'(status_word[3:0]), 32'(m_flags));
        check(status_word[2] == m_flags[2], "R4", 32'(status_word[2]), 32'(m_flags[2]));
        check(dms_event == (m_flags != 0), "R9", 32'(dms_event), 32'(m_flags != 0));
    endtask

    task automatic step(input bit d, input bit r, input bit s, input bit c,
                        input bit wr, input logic [7:0] a, input logic [31:0] wd);
        @(negedge clk);
        if (!rst) compare_all();
        dcd_in = d; ri_in = r; dsr_in = s; cts_in = c;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++)
            step(dcd_in, ri_in, dsr_in, cts_in, 0, 8'h00, 32'h0);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status_word == 32'h0, "R1", status_word, 32'h0);
        check(dms_event == 1'b0, "R1", 32'(dms_event), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(status_word == 32'h0, "R1", status_word, 32'h0);

        phase = "R3 cts rise";
        step(0, 0, 0, 1, 0, 8'h00, 0);
        idle(5);
        phase = "R5 clear cts only";
        step(1, 0, 1, 1, 1, 8'h28, 32'h1);
        idle(5);
        phase = "R5 partial clear";
        step(dcd_in, ri_in, dsr_in, cts_in, 1, 8'h28, 32'h8);
        idle(2);
        step(dcd_in, ri_in, dsr_in, cts_in, 1, 8'h28, 32'hF);
        idle(2);
        check(status_word[3:0] == 4'h0, "R5", 32'(status_word[3:0]), 32'h0);

        phase = "R4 ring rise";
        step(dcd_in, 1, dsr_in, cts_in, 0, 8'h00, 0);
        idle(5);
        check(status_word[2] == 1'b0, "R4", 32'(status_word[2]), 32'h0);
        phase = "R4 ring fall";
        step(dcd_in, 0, dsr_in, cts_in, 0, 8'h00, 0);
        idle(5);
        check(status_word[2] == 1'b1, "R4", 32'(status_word[2]), 32'h1);

        phase = "R7 mode and R8 level write";
        step(dcd_in, ri_in, dsr_in, cts_in, 1, 8'h28, 32'hFFFF_FFF0);
        idle(2);
        check(status_word[8] == 1'b1, "R7", 32'(status_word[8]), 32'h1);
        phase = "R8 foreign address";
        step(dcd_in, ri_in, dsr_in, cts_in, 1, 8'h2C, 32'h0000_000F);
        idle(2);
        step(dcd_in, ri_in, dsr_in, cts_in, 1, 8'h28, 32'h0000_000F);
        idle(2);
        check(dms_event == 1'b0, "R9", 32'(dms_event), 32'h0);

        phase = "R6 change during clear";
        for (int k = 0; k < 12; k++)
            step(dcd_in, ri_in, ~dsr_in, cts_in, 1, 8'h28, 32'hF);
        check(status_word[1] == 1'b1, "R6", 32'(status_word[1]), 32'h1);
        idle(4);

        phase = "R9 random mix";
        for (int k = 0; k < 600; k++) begin
            logic [7:0] a;
            a = ($urandom_range(0, 3) == 0) ? 8'h2C : 8'h28;
            step($urandom_range(0, 7) == 0 ? ~dcd_in : dcd_in,
                 $urandom_range(0, 5) == 0 ? ~ri_in  : ri_in,
                 $urandom_range(0, 7) == 0 ? ~dsr_in : dsr_in,
                 $urandom_range(0, 3) == 0 ? ~cts_in : cts_in,
                 $urandom_range(0, 4) == 0, a, $urandom());
        end
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule